// File: doc/BRIEF.md
# Binary BCH Error-Locator Solver

This block turns the syndromes of a binary BCH codeword into the error-locator polynomial sigma(x) and its degree. It runs the simplified Berlekamp-Massey recursion for binary codes. That form needs only the odd-numbered steps, so a code that corrects t errors takes at most t iterations. The field is GF(2^M), defined by a primitive polynomial given as a parameter. Products and quotients are formed in the log domain, using antilog and log tables that are computed at elaboration.

A caller presents 2t syndromes and the run-time capability t, then pulses start. The block captures both values and works row by row. Each row holds the mu value, the discrepancy, the polynomial and its degree. A run stops early once enough consecutive discrepancies have come out zero; the number needed depends on t and on the current degree. At the end the block publishes the coefficients sigma_0..sigma_T_MAX and the degree, and pulses done for one cycle. Syndrome generation and the root search are done elsewhere.

Top module: `bm_solver`

## Requirements
- R1: During and after a synchronous reset, done_o is 0 and sig_o and deg_o are all zero until the first result.
- R2: When every syndrome is zero, the result is sigma(x) = 1 with degree 0.
- R3: For a single error with locator X, the result is sigma(x) = 1 + X·x with degree 1.
- R4: For v <= t errors with distinct locators X_k, the result is the product of (1 + X_k·x) and the degree is v. Coefficient k sits in sig_o[k*M +: M], in the polynomial basis of GF(2^M) generated by POLY (default M=5, POLY=0x25), with alpha = 0b00010. Syndrome S_j sits in syn_i[(j-1)*M +: M] for j = 1..2*T_MAX.
- R5: With t_i below T_MAX, the syndromes above index 2t have no effect on the result.
- R6: done_o is high for exactly one cycle per result, and sig_o and deg_o hold their values between done pulses.
- R7: In every result, sigma_0 is 1 and every coefficient above the reported degree is zero.
- R8: A start pulse that arrives while a solve is in progress is ignored: no extra result appears, and the running solve keeps the syndromes it captured.
- R9: A solve that runs all t iterations raises done_o 2t-1 rising edges after the edge that samples start. With all-zero syndromes and t = 4, the early exit raises it after 5 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a solve when the block is idle |
| t_i | input | $clog2(T_MAX+1) | Correction capability t, from 1 to T_MAX |
| syn_i | input | 2*T_MAX*M | Syndromes S_1..S_2T, S_j at bit offset (j-1)*M |
| sig_o | output | (T_MAX+1)*M | Locator coefficients, sigma_k at bit offset k*M |
| deg_o | output | $clog2(3*T_MAX+2) | Degree of sigma(x) |
| done_o | output | 1 | One-cycle pulse when sig_o and deg_o are updated |

## Verification
The solver is driven with syndromes that the bench builds from chosen error positions: none, one, two, three and four errors at t = 4. Each result is compared with the product of (1 + X·x) over the error locators, which is formed by shift-and-add field multiplication. Comparing against the factored form separates a correct recursion from one that picks the wrong earlier row or misaligns the shifted term, since either mistake leaves a polynomial whose roots are not the error locators. The all-zero pattern and a one-error, t = 1 solve are timed to tell the early-exit path from a full run. A t = 2 case with junk above S_4 shows that the unused syndromes are ignored. A second start issued mid-run checks that the syndromes captured at the first start are kept.

// File: rtl/bm_pkg.sv
package bm_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_UPD, ST_DISC} bm_state_e;

  // alpha^e in polynomial basis, evaluated at elaboration time
  function automatic int gf_alog_const(int e, int m, int poly);
    int v;
    v = 1;
    for (int k = 0; k < e; k++) begin
      v = v << 1;
      if (((v >> m) & 1) != 0) v = v ^ poly;
    end
    return v;
  endfunction

  // discrete log of val (0 maps to 0; callers gate zero operands)
  function automatic int gf_log_const(int val, int m, int poly);
    int v;
    int res;
    v   = 1;
    res = 0;
    for (int e = 0; e < (1 << m) - 1; e++) begin
      if (v == val) res = e;
      v = v << 1;
      if (((v >> m) & 1) != 0) v = v ^ poly;
    end
    return res;
  endfunction

endpackage

// File: rtl/bm_log_rom.sv
module bm_log_rom
  import bm_pkg::*;
#(
  parameter int M    = 5,
  parameter int POLY = 37
) (
  input  logic [M-1:0] val_i,
  output logic [M-1:0] log_o
);
  localparam int SZ = 1 << M;

  logic [M-1:0] tab [SZ];

  for (genvar g = 0; g < SZ; g++) begin : g_ent
    assign tab[g] = M'(gf_log_const(g, M, POLY));
  end

  assign log_o = tab[val_i];
endmodule

// File: rtl/bm_alog_rom.sv
module bm_alog_rom
  import bm_pkg::*;
#(
  parameter int M    = 5,
  parameter int POLY = 37
) (
  input  logic [M-1:0] exp_i,
  output logic [M-1:0] val_o
);
  localparam int SZ = 1 << M;

  logic [M-1:0] tab [SZ];

  for (genvar g = 0; g < SZ; g++) begin : g_ent
    assign tab[g] = M'(gf_alog_const(g, M, POLY));
  end

  assign val_o = tab[exp_i];
endmodule

// File: rtl/bm_gf_term.sv
// y = a * b / c in GF(2^M); zero when a or b is zero; c must be nonzero.
module bm_gf_term #(
  parameter int M    = 5,
  parameter int POLY = 37
) (
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  input  logic [M-1:0] c_i,
  output logic [M-1:0] y_o
);
  localparam int NN = (1 << M) - 1;
  localparam int SW = M + 2;

  logic [M-1:0]  la, lb, lc, idx, ev;
  logic [SW-1:0] s0;

  bm_log_rom #(.M(M), .POLY(POLY)) u_la (.val_i(a_i), .log_o(la));
  bm_log_rom #(.M(M), .POLY(POLY)) u_lb (.val_i(b_i), .log_o(lb));
  bm_log_rom #(.M(M), .POLY(POLY)) u_lc (.val_i(c_i), .log_o(lc));

  assign s0 = {2'b00, la} + {2'b00, lb} + SW'(NN) - {2'b00, lc};

  always_comb begin
    if (s0 >= SW'(2 * NN))      idx = M'(s0 - SW'(2 * NN));
    else if (s0 >= SW'(NN))     idx = M'(s0 - SW'(NN));
    else                        idx = M'(s0);
  end

  bm_alog_rom #(.M(M), .POLY(POLY)) u_ex (.exp_i(idx), .val_o(ev));

  assign y_o = (a_i == '0 || b_i == '0) ? '0 : ev;
endmodule

// File: rtl/bm_solver.sv
module bm_solver
  import bm_pkg::*;
#(
  parameter int M     = 5,
  parameter int POLY  = 37,
  parameter int T_MAX = 4,
  localparam int NC   = T_MAX + 1,
  localparam int NS   = 2 * T_MAX,
  localparam int TW   = $clog2(T_MAX + 1),
  localparam int DW   = $clog2(3 * T_MAX + 2)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [TW-1:0]    t_i,
  input  logic [NS*M-1:0]  syn_i,
  output logic [NC*M-1:0]  sig_o,
  output logic [DW-1:0]    deg_o,
  output logic             done_o
);
  localparam int NROW = T_MAX + 2;
  localparam int IW   = $clog2(NROW);
  localparam int CW   = $clog2(T_MAX + 2);

  typedef logic [M-1:0] gf_t;

  bm_state_e     state_q;
  logic [IW-1:0] it_q, nx, rho_c;
  logic [CW-1:0] zc_q, zc_n;
  logic [TW-1:0] t_q;

  // per-row storage; degree kept as the true degree (half of the doubled form)
  gf_t           syn_q [NS+1];
  gf_t           sig_q [NROW][NC];
  logic [DW-1:0] deg_q [NROW];
  gf_t           dis_q [NROW];

  gf_t           cur_d;
  gf_t           upd_t [NC];
  gf_t           pub_sig [NC];
  logic [DW-1:0] pub_deg;
  int            shift, deg_new;
  logic          early;

  gf_t           dsig [NC];
  gf_t           dsyn [NC];
  gf_t           dterm [NC];
  gf_t           nd;

  assign nx    = it_q + IW'(1);
  assign cur_d = dis_q[it_q];

  // earlier row with nonzero discrepancy and largest delta; first wins on ties
  always_comb begin
    int best;
    int dl;
    best  = -1;
    rho_c = '0;
    for (int r = 0; r < NROW; r++) begin
      dl = (r == 0) ? -1 : 2 * (r - 1) - int'(deg_q[r]);
      if (r < int'(it_q) && dis_q[r] != '0 && dl > best) begin
        best  = dl;
        rho_c = IW'(r);
      end
    end
    shift   = (rho_c == '0) ? 2 * int'(it_q) - 1 : 2 * (int'(it_q) - int'(rho_c));
    deg_new = int'(deg_q[rho_c]) + shift;
    if (int'(deg_q[it_q]) > deg_new) deg_new = int'(deg_q[it_q]);
  end

  // scaled earlier polynomial: d_i / d_rho * sigma_rho[j]
  for (genvar j = 0; j < NC; j++) begin : g_upd
    bm_gf_term #(.M(M), .POLY(POLY)) u_term (
      .a_i(cur_d),
      .b_i(sig_q[rho_c][j]),
      .c_i(dis_q[rho_c]),
      .y_o(upd_t[j])
    );
  end

  // candidate row i+1: copy on zero discrepancy, else add the shifted term
  always_comb begin
    for (int k = 0; k < NC; k++) begin
      pub_sig[k] = sig_q[it_q][k];
      if (cur_d != '0 && k >= shift && (k - shift) < NC)
        pub_sig[k] = pub_sig[k] ^ upd_t[k - shift];
    end
    pub_deg = (cur_d == '0) ? deg_q[it_q] : DW'(deg_new);
  end

  // early-exit threshold from t and the current degree
  always_comb begin
    int q;
    int thr;
    zc_n  = zc_q + CW'(1);
    q     = int'(t_q) - int'(deg_q[it_q]) - 1;
    thr   = q / 2 + (((q % 2) != 0) ? 2 : 1);
    early = (cur_d == '0) && (int'(zc_n) == thr);
  end

  // next discrepancy operands: sigma_(i+1)[k] and S_(2i+1-k)
  always_comb begin
    int base;
    int sx;
    base = 2 * int'(it_q) + 1;
    for (int k = 0; k < NC; k++) begin
      sx      = base - k;
      dsig[k] = sig_q[nx][k];
      dsyn[k] = '0;
      if (k >= 1 && sx >= 1 && sx <= NS && k <= int'(deg_q[nx]))
        dsyn[k] = syn_q[sx];
    end
  end

  assign dterm[0] = '0;
  for (genvar k = 1; k < NC; k++) begin : g_dis
    bm_gf_term #(.M(M), .POLY(POLY)) u_term (
      .a_i(dsig[k]),
      .b_i(dsyn[k]),
      .c_i(gf_t'(1)),
      .y_o(dterm[k])
    );
  end

  always_comb begin
    int base;
    base = 2 * int'(it_q) + 1;
    nd   = (base <= NS) ? syn_q[base] : '0;
    for (int k = 1; k < NC; k++) nd = nd ^ dterm[k];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      it_q    <= '0;
      zc_q    <= '0;
      t_q     <= '0;
      sig_o   <= '0;
      deg_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            t_q       <= t_i;
            syn_q[0]  <= '0;
            for (int j = 1; j <= NS; j++) syn_q[j] <= syn_i[(j-1)*M +: M];
            for (int k = 0; k < NC; k++) begin
              sig_q[0][k] <= (k == 0) ? gf_t'(1) : '0;
              sig_q[1][k] <= (k == 0) ? gf_t'(1) : '0;
            end
            dis_q[0] <= gf_t'(1);
            dis_q[1] <= syn_i[M-1:0];
            deg_q[0] <= '0;
            deg_q[1] <= '0;
            it_q     <= IW'(1);
            zc_q     <= '0;
            state_q  <= ST_UPD;
          end
        end
        ST_UPD: begin
          if (cur_d == '0) zc_q <= zc_n;
          for (int k = 0; k < NC; k++) sig_q[nx][k] <= pub_sig[k];
          deg_q[nx] <= pub_deg;
          if (early || int'(it_q) == int'(t_q)) begin
            for (int k = 0; k < NC; k++) sig_o[k*M +: M] <= pub_sig[k];
            deg_o   <= pub_deg;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_DISC;
          end
        end
        ST_DISC: begin
          dis_q[nx] <= nd;
          it_q      <= nx;
          state_q   <= ST_UPD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bm_solver_chk.sv
module bm_solver_chk #(
  parameter int M     = 5,
  parameter int T_MAX = 4,
  localparam int NC   = T_MAX + 1,
  localparam int DW   = $clog2(3 * T_MAX + 2)
) (
  input logic            clk_i,
  input logic            rst_i,
  input logic [NC*M-1:0] sig_o,
  input logic [DW-1:0]   deg_o,
  input logic            done_o
);
  logic hi_ok;

  always_comb begin
    hi_ok = 1'b1;
    for (int k = 1; k < NC; k++)
      if (k > int'(deg_o) && sig_o[k*M +: M] != '0) hi_ok = 1'b0;
  end

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  p_hold_out_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !done_o |-> ($stable(sig_o) && $stable(deg_o)));

  p_const_one_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> (sig_o[M-1:0] == M'(1)));

  p_upper_zero_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> hi_ok);
endmodule

bind bm_solver bm_solver_chk #(.M(M), .T_MAX(T_MAX)) u_chk (.*);

// File: tb/tb_bm_solver.sv
`timescale 1ns/1ps
module tb_bm_solver;
  localparam int M     = 5;
  localparam int POLY  = 37;
  localparam int T_MAX = 4;
  localparam int NC    = T_MAX + 1;
  localparam int NS    = 2 * T_MAX;
  localparam int TW    = $clog2(T_MAX + 1);
  localparam int DW    = $clog2(3 * T_MAX + 2);
  localparam int NN    = (1 << M) - 1;
  localparam logic [M-1:0] PLOW = M'(POLY);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start_i = 1'b0;
  logic [TW-1:0]   t_i = '0;
  logic [NS*M-1:0] syn_i = '0;
  logic [NC*M-1:0] sig_o;
  logic [DW-1:0]   deg_o;
  logic            done_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit prev_done = 1'b0;

  typedef struct {
    logic [NC*M-1:0] sig;
    int              deg;
    int              lat;
    int              scyc;
    string           tag;
  } item_t;

  item_t sb_q[$];
  logic [NC*M-1:0] last_sig;
  int              last_deg;

  bm_solver #(.M(M), .POLY(POLY), .T_MAX(T_MAX)) dut (
    .clk_i(clk), .rst_i(rst), .start_i(start_i), .t_i(t_i),
    .syn_i(syn_i), .sig_o(sig_o), .deg_o(deg_o), .done_o(done_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [M-1:0] gmul(logic [M-1:0] a, logic [M-1:0] b);
    logic [M-1:0] r;
    logic [M-1:0] x;
    r = '0;
    x = a;
    for (int k = 0; k < M; k++) begin
      if (b[k]) r = r ^ x;
      x = {x[M-2:0], 1'b0} ^ (x[M-1] ? PLOW : '0);
    end
    return r;
  endfunction

  function automatic logic [M-1:0] gpow(int e);
    logic [M-1:0] r;
    r = M'(1);
    for (int k = 0; k < (e % NN); k++) r = gmul(r, M'(2));
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: build syndromes from error positions, push expectation, pulse start
  task automatic run_case(input int tt, input int n, input int p0, input int p1,
                          input int p2, input int p3, input bit junk,
                          input int lat, input bit jam, input string tag);
    int           pos[4];
    logic [M-1:0] poly[NC];
    logic [M-1:0] s;
    logic [M-1:0] xl;
    item_t        it;
    pos = '{p0, p1, p2, p3};
    for (int k = 0; k < NC; k++) poly[k] = (k == 0) ? M'(1) : '0;
    for (int e = 0; e < n; e++) begin
      xl = gpow(pos[e]);
      for (int k = NC - 1; k >= 1; k--) poly[k] = poly[k] ^ gmul(xl, poly[k-1]);
    end
    for (int j = 1; j <= NS; j++) begin
      s = '0;
      for (int e = 0; e < n; e++) s = s ^ gpow(j * pos[e]);
      if (junk && j > 2 * tt) s = M'((j * 7 + 5) % (1 << M));
      syn_i[(j-1)*M +: M] = s;
    end
    it.sig = '0;
    for (int k = 0; k < NC; k++) it.sig[k*M +: M] = poly[k];
    it.deg = n;
    it.lat = lat;
    it.tag = tag;
    @(negedge clk);
    it.scyc = cyc + 1;
    sb_q.push_back(it);
    last_sig = it.sig;
    last_deg = it.deg;
    t_i = TW'(tt);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (jam) begin
      @(negedge clk);
      syn_i = {NS{M'(9)}};
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (sb_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: pop and compare on each done pulse
  always @(negedge clk) begin
    item_t it;
    if (!rst) begin
      if (done_o) begin
        check(!prev_done, "R6", "done longer than one cycle", 1, 0);
        if (sb_q.size() == 0) begin
          check(1'b0, "R8", "done without a pending start", 1, 0);
        end else begin
          it = sb_q.pop_front();
          check(sig_o == it.sig, it.tag, "sigma coefficients", longint'(sig_o), longint'(it.sig));
          check(int'(deg_o) == it.deg, it.tag, "degree", deg_o, it.deg);
          if (it.lat >= 0)
            check(cyc - it.scyc == it.lat, "R9", "latency", cyc - it.scyc, it.lat);
        end
      end
      prev_done = done_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
    check(sig_o == '0, "R1", "sigma after reset", longint'(sig_o), 0);
    check(deg_o == '0, "R1", "degree after reset", deg_o, 0);

    run_case(4, 0, 0, 0, 0, 0, 1'b0, 5, 1'b0, "R2");   // zero syndromes, early exit (R9)
    run_case(4, 1, 3, 0, 0, 0, 1'b0, -1, 1'b0, "R3");
    run_case(1, 1, 12, 0, 0, 0, 1'b0, 1, 1'b0, "R3");  // full run at t=1 (R9)
    run_case(4, 2, 1, 20, 0, 0, 1'b0, -1, 1'b0, "R4");
    run_case(4, 3, 0, 7, 29, 0, 1'b0, -1, 1'b0, "R4");
    run_case(4, 4, 2, 11, 17, 30, 1'b0, 7, 1'b0, "R4");
    run_case(2, 2, 5, 9, 0, 0, 1'b1, 3, 1'b0, "R5");   // junk above S_4
    run_case(4, 3, 4, 13, 22, 0, 1'b0, -1, 1'b1, "R8"); // second start mid-run

    // R6: outputs held after the pulse, no stray done (monitor flags R8)
    repeat (10) @(negedge clk);
    check(sig_o == last_sig, "R6", "sigma held", longint'(sig_o), longint'(last_sig));
    check(int'(deg_o) == last_deg, "R6", "degree held", deg_o, last_deg);
    check(sig_o[M-1:0] == M'(1), "R7", "constant term", sig_o[M-1:0], 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule